// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block stores received Ethernet frames in a circular region of packet memory organised as 256-byte pages. The region is bounded by a first page and a one-past-last page supplied by configuration. Each frame occupies a whole number of pages. Its first four bytes are a small header that gives a status code, the page where the following frame will begin, and the number of bytes stored. Frame bytes follow the header and fold back to the first page of the region when they reach its end.

Software sets the starting write page, the region limits and a read-side boundary page. Before presenting a frame, the upstream source watches a ready flag. That flag says whether one full-size frame (1514 bytes plus header) is certain to fit ahead of the boundary. Frames shorter than the Ethernet minimum are padded with zeros. When a frame has been written, the write page moves past it and a sticky receive-done flag rises so that an interrupt can be raised.

Top module: `rx_ring_writer`

## Requirements
- R1: The header occupies the four bytes at byte address base = cur_pg*256. Byte 0 holds the status code 0x01, byte 1 the next page, byte 2 the stored length low byte and byte 3 the stored length high byte.
- R2: The stored length is the stored frame length (after padding) plus 4.
- R3: Frame byte k is written at base+4+k. Whenever the address reaches stop_pg*256 it continues at start_pg*256.
- R4: The next page is cur_pg plus ceil((stored length + 4) / 256).
- R5: If that sum reaches or passes stop_pg, (stop_pg - start_pg) is subtracted from it.
- R6: After the last header byte, cur_pg holds the next page and rx_done is set. rx_done stays set until done_clr is high at a clock edge, and a new setting wins over a clear in the same cycle.
- R7: can_rx is 0 while stop_cmd is 1 or while a frame is being written. Otherwise it is 1 exactly when the free space is at least 1518 bytes.
- R8: With cur = cur_pg*256 and bnd = bound_pg*256, the free space is bnd - cur when cur < bnd. Otherwise it is (stop_pg - start_pg)*256 - (cur - bnd).
- R9: A frame shorter than 60 bytes is followed in memory by zero bytes up to 60 bytes of frame data.
- R10: A frame whose start marker arrives while can_rx is 0 is discarded up to its end marker. Nothing is written, and cur_pg and rx_done do not change.
- R11: When cur_load is high at a clock edge, cur_pg takes cur_load_pg. A frame completing in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_cmd | input | 1 | Receiver stopped; blocks new frames |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | One past the last page of the ring |
| bound_pg | input | 8 | Page up to which software has consumed frames |
| cur_load | input | 1 | Load strobe for the write page |
| cur_load_pg | input | 8 | Value loaded into the write page |
| done_clr | input | 1 | Clears rx_done |
| in_valid | input | 1 | in_data carries a frame byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| can_rx | output | 1 | Room for a full-size frame and block idle |
| cur_pg | output | 8 | Current write page |
| rx_done | output | 1 | Sticky frame-stored flag |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |

## Verification
The bench aims at the page-rounding edges: a stored length plus CRC of exactly 256 must take one page and one byte more must take two. A design off by one in the rounding would link frames a page early or late. It lands a next page exactly on the stop page, which must fold to the start page. A design that compares with "greater than" would leave the write page outside the ring. It sends a frame that runs across the ring end, where a missing wrap would write past the region. It also checks the free-space threshold on both sides of the boundary pointer at exactly six and five free pages: a wrong comparison or a wrong branch would accept a frame that can overrun unread data. Short frames must show zero padding and a length of 64. Dropped frames must leave no write at all.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DATA = 3'd1,
        S_PAD  = 3'd2,
        S_HDR  = 3'd3,
        S_DROP = 3'd4
    } rxr_state_e;

    localparam logic [7:0] RX_STATUS_OK = 8'h01;
    localparam int         HDR_BYTES    = 4;
    localparam int         CRC_BYTES    = 4;
endpackage

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
    parameter int PW   = 8,
    parameter int LW   = 16,
    parameter int CRCB = 4
) (
    input  logic [PW-1:0] base_pg,
    input  logic [LW-1:0] stored_len,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    output logic [PW-1:0] next_pg
);
    localparam int SW   = LW + 1;
    localparam int PGW  = SW - 8;
    localparam int SUMW = ((PW > PGW) ? PW : PGW) + 1;

    logic [SW-1:0]   span_bytes;
    logic [PGW-1:0]  span_pages;
    logic [SUMW-1:0] raw_sum;
    logic [SUMW-1:0] wrapped;

    always_comb begin
        span_bytes = SW'(stored_len) + SW'(CRCB + 255);
        span_pages = PGW'(span_bytes >> 8);
        raw_sum    = SUMW'(base_pg) + SUMW'(span_pages);
        if (raw_sum >= SUMW'(stop_pg))
            wrapped = raw_sum - SUMW'(stop_pg - start_pg);
        else
            wrapped = raw_sum;
        next_pg = PW'(wrapped);
    end
endmodule

// File: rtl/rxr_space_calc.sv
module rxr_space_calc #(
    parameter int PW       = 8,
    parameter int NEED_BYT = 1518
) (
    input  logic [PW-1:0] cur_pg,
    input  logic [PW-1:0] bound_pg,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    input  logic          stop_cmd,
    input  logic          idle,
    output logic          can_rx
);
    localparam int FW = PW + 9;

    logic [PW:0]   free_pg;
    logic [FW-1:0] free_bytes;

    always_comb begin
        if (cur_pg < bound_pg)
            free_pg = {1'b0, bound_pg} - {1'b0, cur_pg};
        else
            free_pg = ({1'b0, stop_pg} - {1'b0, start_pg})
                    - ({1'b0, cur_pg} - {1'b0, bound_pg});
        free_bytes = {free_pg, 8'h00};
        can_rx     = idle && !stop_cmd && (free_bytes >= FW'(NEED_BYT));
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PW        = 8,
    parameter int LW        = 16,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_cmd,
    input  logic [PW-1:0]   start_pg,
    input  logic [PW-1:0]   stop_pg,
    input  logic [PW-1:0]   bound_pg,
    input  logic            cur_load,
    input  logic [PW-1:0]   cur_load_pg,
    input  logic            done_clr,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [7:0]      in_data,
    output logic            can_rx,
    output logic [PW-1:0]   cur_pg,
    output logic            rx_done,
    output logic            mem_we,
    output logic [PW+7:0]   mem_addr,
    output logic [7:0]      mem_wdata
);
    localparam int AW = PW + 8;

    typedef struct packed {
        rxr_state_e  st;
        logic [AW-1:0] addr;
        logic [PW-1:0] base;
        logic [LW-1:0] len;
        logic [1:0]    hidx;
        logic [PW-1:0] cur;
        logic          done;
    } wr_state_t;

    wr_state_t     q, d;
    logic [PW-1:0] next_pg;
    logic [LW-1:0] stored_len;
    logic [AW-1:0] ring_lo, ring_hi, first_addr;

    assign stored_len = q.len + LW'(HDR_BYTES);

    rxr_next_page #(.PW(PW), .LW(LW), .CRCB(CRC_BYTES)) u_next (
        .base_pg    (q.base),
        .stored_len (stored_len),
        .start_pg   (start_pg),
        .stop_pg    (stop_pg),
        .next_pg    (next_pg)
    );

    rxr_space_calc #(.PW(PW), .NEED_BYT(MAX_FRAME + HDR_BYTES)) u_space (
        .cur_pg   (q.cur),
        .bound_pg (bound_pg),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .stop_cmd (stop_cmd),
        .idle     (q.st == S_IDLE),
        .can_rx   (can_rx)
    );

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a,
                                           input logic [AW-1:0] lo,
                                           input logic [AW-1:0] hi);
        logic [AW-1:0] n;
        n = a + AW'(1);
        return (n == hi) ? lo : n;
    endfunction

    always_comb begin
        ring_lo    = {start_pg, 8'h00};
        ring_hi    = {stop_pg, 8'h00};
        first_addr = {q.cur, 8'h00} + AW'(HDR_BYTES);
        d          = q;
        mem_we     = 1'b0;
        mem_addr   = q.addr;
        mem_wdata  = 8'h00;
        if (cur_load) d.cur = cur_load_pg;
        if (done_clr) d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (in_valid && in_sop) begin
                    if (can_rx) begin
                        mem_we    = 1'b1;
                        mem_addr  = first_addr;
                        mem_wdata = in_data;
                        d.base    = q.cur;
                        d.addr    = step(first_addr, ring_lo, ring_hi);
                        d.len     = LW'(1);
                        d.hidx    = 2'd0;
                        if (!in_eop)              d.st = S_DATA;
                        else if (1 < MIN_FRAME)   d.st = S_PAD;
                        else                      d.st = S_HDR;
                    end else if (!in_eop) begin
                        d.st = S_DROP;
                    end
                end
            end
            S_DATA: begin
                if (in_valid) begin
                    mem_we    = 1'b1;
                    mem_wdata = in_data;
                    d.addr    = step(q.addr, ring_lo, ring_hi);
                    d.len     = q.len + LW'(1);
                    if (in_eop)
                        d.st = (q.len + LW'(1) < LW'(MIN_FRAME)) ? S_PAD : S_HDR;
                end
            end
            S_PAD: begin
                mem_we = 1'b1;
                d.addr = step(q.addr, ring_lo, ring_hi);
                d.len  = q.len + LW'(1);
                if (q.len + LW'(1) >= LW'(MIN_FRAME)) d.st = S_HDR;
            end
            S_HDR: begin
                mem_we   = 1'b1;
                mem_addr = {q.base, 6'd0, q.hidx};
                case (q.hidx)
                    2'd0:    mem_wdata = RX_STATUS_OK;
                    2'd1:    mem_wdata = 8'(next_pg);
                    2'd2:    mem_wdata = stored_len[7:0];
                    default: mem_wdata = stored_len[15:8];
                endcase
                d.hidx = q.hidx + 2'd1;
                if (q.hidx == 2'd3) begin
                    d.cur  = next_pg;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_DROP: begin
                if (in_valid && in_eop) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.addr <= '0;
            q.base <= '0;
            q.len  <= '0;
            q.hidx <= '0;
            q.cur  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cur_pg  = q.cur;
    assign rx_done = q.done;

    // R3: every frame or pad byte lands inside the ring
    p_write_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && q.st != S_HDR) |-> (mem_addr >= ring_lo && mem_addr < ring_hi));
    // R9: padding bytes are zero
    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PAD) |-> (mem_we && mem_wdata == 8'h00));
    // R6: the last header byte is followed by the done flag
    p_commit_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HDR && q.hidx == 2'd3) |=> rx_done);
    // R7: busy blocks new frames
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |-> !can_rx);
    // R10: a discarded frame writes nothing
    p_drop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DROP) |-> !mem_we);
    // R10: a discarded frame leaves the write page alone
    p_drop_keeps_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DROP && !cur_load) |=> $stable(cur_pg));
endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_cmd = 1'b0;
    logic [7:0]  start_pg = 8'h40, stop_pg = 8'h80, bound_pg = 8'h40;
    logic        cur_load = 1'b0;
    logic [7:0]  cur_load_pg = 8'h00;
    logic        done_clr = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        can_rx, rx_done, mem_we;
    logic [7:0]  cur_pg, mem_wdata;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [7:0] bmem [int];

    always #2 clk = ~clk;

    rx_ring_writer i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd),
        .start_pg(start_pg), .stop_pg(stop_pg), .bound_pg(bound_pg),
        .cur_load(cur_load), .cur_load_pg(cur_load_pg), .done_clr(done_clr),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .can_rx(can_rx), .cur_pg(cur_pg), .rx_done(rx_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
        end
    end

    // {start, stop, bound, cur, frame length, expected next page}
    localparam logic [55:0] VEC [8] = '{
        {8'h40, 8'h80, 8'h40, 8'h46, 16'd100,  8'h47},
        {8'h40, 8'h80, 8'h40, 8'h47, 16'd60,   8'h48},
        {8'h40, 8'h80, 8'h40, 8'h50, 16'd20,   8'h51},
        {8'h40, 8'h80, 8'h40, 8'h51, 16'd248,  8'h52},
        {8'h40, 8'h80, 8'h40, 8'h52, 16'd249,  8'h54},
        {8'h40, 8'h50, 8'h48, 8'h4F, 16'd300,  8'h41},
        {8'h40, 8'h50, 8'h44, 8'h4E, 16'd400,  8'h40},
        {8'h40, 8'h80, 8'h40, 8'h60, 16'd1514, 8'h66}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int rd(input int a);
        return bmem.exists(a) ? int'(bmem[a]) : -1;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 13 + k * 7 + 1);
    endfunction

    task automatic setup(input logic [7:0] s, input logic [7:0] e,
                         input logic [7:0] b, input logic [7:0] c);
        @(negedge clk);
        start_pg = s; stop_pg = e; bound_pg = b;
        cur_load = 1'b1; cur_load_pg = c; done_clr = 1'b1;
        @(negedge clk);
        cur_load = 1'b0; done_clr = 1'b0;
    endtask

    task automatic send(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (k == 0);
            in_eop   = (k == n - 1);
            in_data  = pat(seed, k);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 200 && !rx_done; t++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(cur_pg == 8'h00 && rx_done == 1'b0 && mem_we == 1'b0, "R6 reset",
              {cur_pg, 7'd0, rx_done}, 0);

        // R11: load of the write page
        setup(8'h40, 8'h80, 8'h40, 8'h46);
        check(cur_pg == 8'h46, "R11 load", cur_pg, 8'h46);

        // Table of frames
        for (int v = 0; v < 8; v++) begin
            logic [7:0] s, e, b, c, nx;
            int n, plen, stored, base, bad, a, exp_b;
            {s, e, b, c, n[15:0], nx} = VEC[v];
            n = n & 16'hFFFF;
            bmem.delete();
            setup(s, e, b, c);
            check(can_rx == 1'b1, "R7 ready", can_rx, 1);
            send(n, v);
            wait_done();
            plen   = (n < 60) ? 60 : n;
            stored = plen + 4;
            base   = int'(c) * 256;
            check(rd(base) == 1, "R1 status", rd(base), 1);
            check(rd(base + 1) == int'(nx), "R1 R4 R5 next page", rd(base + 1), nx);
            check(rd(base + 2) == (stored & 255), "R1 R2 len lo", rd(base + 2), stored & 255);
            check(rd(base + 3) == (stored >> 8), "R1 R2 len hi", rd(base + 3), stored >> 8);
            bad = -1;
            for (int k = 0; k < plen; k++) begin
                a = base + 4 + k;
                if (a >= int'(e) * 256) a = a - (int'(e) - int'(s)) * 256;
                exp_b = (k < n) ? int'(pat(v, k)) : 0;
                if (rd(a) != exp_b && bad < 0) bad = k;
            end
            check(bad < 0, (n < 60) ? "R3 R9 data/pad" : "R3 data", bad, -1);
            check(cur_pg == nx && rx_done == 1'b1, "R6 commit", cur_pg, nx);
        end

        // R6: clear of the done flag
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        check(rx_done == 1'b0, "R6 clear", rx_done, 0);

        // R7: busy while padding
        setup(8'h40, 8'h80, 8'h40, 8'h46);
        send(20, 9);
        check(can_rx == 1'b0, "R7 busy", can_rx, 0);
        wait_done();

        // R8: threshold on both sides of the boundary
        setup(8'h40, 8'h80, 8'h46, 8'h40);
        @(negedge clk); check(can_rx == 1'b1, "R8 below bnd 6 pages", can_rx, 1);
        setup(8'h40, 8'h80, 8'h45, 8'h40);
        @(negedge clk); check(can_rx == 1'b0, "R8 below bnd 5 pages", can_rx, 0);
        setup(8'h40, 8'h80, 8'h40, 8'h7A);
        @(negedge clk); check(can_rx == 1'b1, "R8 above bnd 6 pages", can_rx, 1);
        setup(8'h40, 8'h80, 8'h40, 8'h7B);
        @(negedge clk); check(can_rx == 1'b0, "R8 above bnd 5 pages", can_rx, 0);

        // R7 and R10: stopped receiver drops a frame
        setup(8'h40, 8'h80, 8'h40, 8'h46);
        stop_cmd = 1'b1;
        @(negedge clk);
        check(can_rx == 1'b0, "R7 stop", can_rx, 0);
        begin
            int w0;
            w0 = wr_cnt;
            send(80, 3);
            repeat (10) @(negedge clk);
            check(wr_cnt == w0, "R10 no write", wr_cnt - w0, 0);
            check(cur_pg == 8'h46 && rx_done == 1'b0, "R10 no state change", cur_pg, 8'h46);
        end
        stop_cmd = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule